// File: doc/BRIEF.md
# Windowed Watchdog Timer with Protected Reload

This block is a down-counting watchdog for a system controller. Once software starts it, the counter steps down by one on every count tick. Software keeps it alive by feeding it with a fixed two-write sequence, and each feed reloads the counter from a time-out constant. A feed is accepted only inside a window. If the counter is still above the window value, the feed is rejected and treated as an error. When the counter reaches zero, or software misbehaves, the block raises a sticky time-out flag. If resets have been armed, it also raises a chip-reset request.

A warning threshold raises a warning flag before the time-out, so software gets a last chance to act. Two mode bits are sticky and can only be set once: the reset-arm bit and the protect bit. With the protect bit set, the time-out constant can only be rewritten late in the count, when the counter is below both the warning threshold and the window value. Any earlier attempt is refused and counted as a violation.

Software reaches the block through a simple write port with five registers: mode, time-out constant, feed, warning threshold and window. The counter, the time-out constant and the mode bits are visible on read-back outputs. A separate tick input sets the count rate.

Top module: `winwdt`

## Requirements
- R1: After reset, the counter and the time-out constant both hold RELOAD_RST, every mode bit reads 0, and irq_o and rst_req_o are 0. The mode bits are run (bit 0), reset-arm (bit 1), time-out flag (bit 2), warning flag (bit 3) and protect (bit 4).
- R2: The counter steps down by exactly one on each cycle where tick_i is 1 and run is 1. Writing run=0 holds the counter.
- R3: The counter stops at 0 and never wraps. The step from 1 to 0 sets the time-out flag.
- R4: Writing 1 to reset-arm sets it. A later write of 0 leaves it at 1.
- R5: Whenever the time-out flag sets while reset-arm is 1, rst_req_o rises and stays high until reset. With reset-arm 0, rst_req_o stays 0.
- R6: A mode write with bit 2 at 0 clears the time-out flag. A mode write with bit 2 at 1 leaves the flag unchanged.
- R7: While run is 1 and the counter equals the warning threshold, the warning flag sets. A mode write with bit 3 at 1 clears it.
- R8: A clear of the warning flag is ignored while the counter equals the warning threshold.
- R9: Writing 1 to protect sets it. A later write of 0 leaves it at 1.
- R10: A feed is a write of 0xAA to the feed register (address 2) followed by a write of 0x55, with no other register write in between. When the counter is at or below the window value, a feed loads the counter with the time-out constant.
- R11: Any feed-register write other than 0xAA, or 0x55 not preceded by an arming 0xAA, sets the time-out flag and leaves the counter unchanged.
- R12: A complete feed while the counter is above the window value sets the time-out flag and does not reload the counter.
- R13: With protect 0, a write to the time-out constant (address 1) always lands. With protect 1, it lands only when the counter is below both the warning threshold (address 3) and the window value (address 4). Otherwise the constant is kept and the time-out flag sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count strobe; one step per high cycle while running |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select: 0 mode, 1 time-out constant, 2 feed, 3 warning threshold, 4 window |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| reload_o | output | CNT_W | Current time-out constant |
| mode_o | output | 5 | Mode bits {protect, warning, time-out, reset-arm, run} |
| irq_o | output | 1 | Interrupt: warning flag or time-out flag set |
| rst_req_o | output | 1 | Chip-reset request |

## Verification
The random phase loads random time-out constants and runs the counter with a random on/off tick pattern, with reset-arm chosen at random. This shows whether gaps in the tick stream are honoured, and whether the time-out and reset request appear exactly when the number of ticks taken reaches the constant. Directed sequences then target the rules a random run rarely reaches:
- a feed made inside the window versus one made above it;
- a broken or unarmed feed;
- a warning clear attempted while the counter ties with the threshold, and again after it has moved past;
- a write to the time-out constant under protect, both before and after the counter drops below both limits.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  typedef enum logic [2:0] {
    A_MODE   = 3'd0,
    A_RELOAD = 3'd1,
    A_FEED   = 3'd2,
    A_WARN   = 3'd3,
    A_WINDOW = 3'd4
  } reg_addr_e;

  localparam int M_RUN   = 0;
  localparam int M_RSTEN = 1;
  localparam int M_TOF   = 2;
  localparam int M_WARN  = 3;
  localparam int M_PROT  = 4;
  localparam int MODE_W  = 5;

  localparam logic [7:0] FEED_ARM  = 8'hAA;
  localparam logic [7:0] FEED_FIRE = 8'h55;
endpackage

// File: rtl/winwdt_feed.sv
module winwdt_feed #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_wr_i,
  input  logic          feed_wr_i,
  input  logic [DW-1:0] data_i,
  output logic          seq_ok_o,
  output logic          seq_bad_o
);
  import winwdt_pkg::*;

  localparam logic [DW-1:0] ARM_V  = DW'(FEED_ARM);
  localparam logic [DW-1:0] FIRE_V = DW'(FEED_FIRE);

  logic armed_q, armed_d;
  logic is_arm, is_fire;

  always_comb begin
    is_arm    = (data_i == ARM_V);
    is_fire   = (data_i == FIRE_V);
    seq_ok_o  = feed_wr_i && armed_q && is_fire;
    seq_bad_o = feed_wr_i && !is_arm && !(armed_q && is_fire);
    if (feed_wr_i)     armed_d = is_arm;
    else if (any_wr_i) armed_d = 1'b0;
    else               armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // a completed feed must have been armed by the previous feed-register write
  p_fire_after_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_wr_i && data_i == ARM_V) |=> (!feed_wr_i || data_i != FIRE_V || seq_ok_o))
    else $error("p_fire_after_arm_r10");
endmodule

// File: rtl/winwdt_cnt.sv
module winwdt_cnt #(
  parameter int              CW      = 16,
  parameter logic [CW-1:0]   RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] count_o,
  output logic          zero_hit_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          nonzero;

  always_comb begin
    nonzero    = (cnt_q != '0);
    zero_hit_o = dec_i && !load_i && (cnt_q == ONE);
    if (load_i)               cnt_d = load_val_i;
    else if (dec_i && nonzero) cnt_d = cnt_q - ONE;
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0))
    else $error("p_no_wrap_r3");

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && dec_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE))
    else $error("p_step_r2");

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !dec_i) |=> $stable(cnt_q))
    else $error("p_hold_r2");
endmodule

// File: rtl/winwdt.sv
module winwdt #(
  parameter int            CNT_W      = 16,
  parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(8'hFF)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick_i,
  input  logic                            wr_en_i,
  input  logic [2:0]                      wr_addr_i,
  input  logic [CNT_W-1:0]                wr_data_i,
  output logic [CNT_W-1:0]                count_o,
  output logic [CNT_W-1:0]                reload_o,
  output logic [winwdt_pkg::MODE_W-1:0]   mode_o,
  output logic                            irq_o,
  output logic                            rst_req_o
);
  import winwdt_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  logic run_q, rsten_q, tof_q, warn_q, prot_q, rreq_q;
  logic run_d, rsten_d, tof_d, warn_d, prot_d, rreq_d;
  logic [CNT_W-1:0] reload_q, thr_q, win_q;
  logic [CNT_W-1:0] reload_d, thr_d, win_d;

  logic wr_mode, wr_reload, wr_feed, wr_thr, wr_win;
  logic seq_ok, seq_bad, zero_hit;
  logic feed_good, feed_late, below_both, reload_bad, tof_set;
  logic warn_hit, warn_clr;
  logic [CNT_W-1:0] count;

  winwdt_feed #(.DW(CNT_W)) u_feed (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .any_wr_i  (wr_en_i),
    .feed_wr_i (wr_feed),
    .data_i    (wr_data_i),
    .seq_ok_o  (seq_ok),
    .seq_bad_o (seq_bad)
  );

  winwdt_cnt #(.CW(CNT_W), .RST_VAL(RELOAD_RST)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .load_i     (feed_good),
    .load_val_i (reload_q),
    .dec_i      (run_q && tick_i),
    .count_o    (count),
    .zero_hit_o (zero_hit)
  );

  always_comb begin
    wr_mode   = wr_en_i && (wr_addr_i == A_MODE);
    wr_reload = wr_en_i && (wr_addr_i == A_RELOAD);
    wr_feed   = wr_en_i && (wr_addr_i == A_FEED);
    wr_thr    = wr_en_i && (wr_addr_i == A_WARN);
    wr_win    = wr_en_i && (wr_addr_i == A_WINDOW);

    feed_good  = seq_ok && (count <= win_q);
    feed_late  = seq_ok && (count > win_q);
    below_both = (count < thr_q) && (count < win_q);
    reload_bad = wr_reload && prot_q && !below_both;
    tof_set    = zero_hit || seq_bad || feed_late || reload_bad;

    warn_hit = run_q && (count == thr_q);
    warn_clr = wr_mode && wr_data_i[M_WARN] && (count != thr_q);

    run_d   = wr_mode ? wr_data_i[M_RUN] : run_q;
    rsten_d = rsten_q || (wr_mode && wr_data_i[M_RSTEN]);
    prot_d  = prot_q  || (wr_mode && wr_data_i[M_PROT]);
    tof_d   = (wr_mode ? (tof_q && wr_data_i[M_TOF]) : tof_q) || tof_set;
    warn_d  = (warn_q && !warn_clr) || warn_hit;
    rreq_d  = rreq_q || (tof_set && rsten_q);

    reload_d = (wr_reload && !reload_bad) ? wr_data_i : reload_q;
    thr_d    = wr_thr ? wr_data_i : thr_q;
    win_d    = wr_win ? wr_data_i : win_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      run_q    <= 1'b0;
      rsten_q  <= 1'b0;
      tof_q    <= 1'b0;
      warn_q   <= 1'b0;
      prot_q   <= 1'b0;
      rreq_q   <= 1'b0;
      reload_q <= RELOAD_RST;
      thr_q    <= '0;
      win_q    <= '1;
    end else begin
      run_q    <= run_d;
      rsten_q  <= rsten_d;
      tof_q    <= tof_d;
      warn_q   <= warn_d;
      prot_q   <= prot_d;
      rreq_q   <= rreq_d;
      reload_q <= reload_d;
      thr_q    <= thr_d;
      win_q    <= win_d;
    end
  end

  assign count_o   = count;
  assign reload_o  = reload_q;
  assign mode_o    = {prot_q, warn_q, tof_q, rsten_q, run_q};
  assign irq_o     = warn_q || tof_q;
  assign rst_req_o = rreq_q;

  p_rsten_sticky_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsten_q |=> rsten_q) else $error("p_rsten_sticky_r4");

  p_prot_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    prot_q |=> prot_q) else $error("p_prot_sticky_r9");

  p_rst_req_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    ($rose(tof_q) && $past(rsten_q)) |-> rreq_q) else $error("p_rst_req_r5");

  p_warn_tie_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (warn_q && count == thr_q) |=> warn_q) else $error("p_warn_tie_r8");

  p_prot_gate_r13: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_reload && prot_q && !(count < thr_q && count < win_q)) |=> ($stable(reload_q) && tof_q))
    else $error("p_prot_gate_r13");

  p_feed_load_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (seq_ok && count <= win_q) |=> (count == $past(reload_q)))
    else $error("p_feed_load_r10");

  p_late_feed_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    (seq_ok && count > win_q) |=> tof_q) else $error("p_late_feed_r12");
endmodule

// File: tb/test_winwdt.sv
module test_winwdt;
  localparam int CW = 16;
  localparam logic [2:0] AD_MODE = 3'd0, AD_RELOAD = 3'd1, AD_FEED = 3'd2,
                         AD_WARN = 3'd3, AD_WIN = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] count, reload;
  logic [4:0] mode;
  logic irq, rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  winwdt #(.CNT_W(CW), .RELOAD_RST(16'h00FF)) i_winwdt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .count_o(count),
    .reload_o(reload), .mode_o(mode), .irq_o(irq), .rst_req_o(rst_req));

  function automatic logic [CW-1:0] exp_count(input int start, input int steps);
    return (steps >= start) ? '0 : CW'(start - steps);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic feed();
    wr(AD_FEED, 16'h00AA);
    wr(AD_FEED, 16'h0055);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    chk("R1 count", count, 16'h00FF);
    chk("R1 reload", reload, 16'h00FF);
    chk("R1 mode", mode, 5'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 rst_req", rst_req, 1'b0);

    // R2 stopped holds, running steps
    ticks(4);
    chk("R2 stopped", count, 16'h00FF);
    wr(AD_MODE, 16'h0005);
    ticks(5);
    chk("R2 step", count, 16'h00FA);

    // R13 flexible reload, R10 feed
    wr(AD_RELOAD, 16'h0020);
    chk("R13 flexible write", reload, 16'h0020);
    feed();
    chk("R10 feed reload", count, 16'h0020);

    // R3 time-out, no wrap; R5 no request without arm
    ticks(32 + 3);
    chk("R3 stop at zero", count, 16'h0000);
    chk("R3 tof set", mode[2], 1'b1);
    chk("R5 no req unarmed", rst_req, 1'b0);

    // R6 tof clear rules
    wr(AD_MODE, 16'h0005);
    chk("R6 write one keeps", mode[2], 1'b1);
    wr(AD_MODE, 16'h0001);
    chk("R6 write zero clears", mode[2], 1'b0);

    // R8 warn stuck at tie (thr 0, count 0)
    chk("R7 warn at zero tie", mode[3], 1'b1);
    wr(AD_MODE, 16'h000D);
    chk("R8 tie clear ignored", mode[3], 1'b1);
    feed();
    chk("R10 refeed", count, 16'h0020);
    wr(AD_MODE, 16'h000D);
    chk("R7 clear", mode[3], 1'b0);

    // R7 set at threshold
    wr(AD_WARN, 16'h001E);
    ticks(2);
    @(negedge clk);
    chk("R7 warn set", mode[3], 1'b1);
    chk("R7 irq", irq, 1'b1);
    wr(AD_MODE, 16'h000D);
    chk("R8 tie at 1E", mode[3], 1'b1);
    ticks(1);
    wr(AD_MODE, 16'h000D);
    chk("R7 clear after move", mode[3], 1'b0);

    // R11 feed errors
    wr(AD_FEED, 16'h0012);
    chk("R11 bad value tof", mode[2], 1'b1);
    chk("R11 count kept", count, 16'h001D);
    wr(AD_MODE, 16'h0001);
    wr(AD_FEED, 16'h0055);
    chk("R11 unarmed tof", mode[2], 1'b1);
    wr(AD_MODE, 16'h0001);
    wr(AD_FEED, 16'h00AA);
    wr(AD_WARN, 16'h001E);
    wr(AD_FEED, 16'h0055);
    chk("R11 broken seq tof", mode[2], 1'b1);
    chk("R11 broken seq count", count, 16'h001D);
    wr(AD_MODE, 16'h0001);

    // R12 window
    wr(AD_WIN, 16'h0010);
    feed();
    chk("R12 late feed tof", mode[2], 1'b1);
    chk("R12 late feed no load", count, 16'h001D);
    wr(AD_MODE, 16'h0001);
    ticks(14);
    chk("R12 in window count", count, 16'h000F);
    feed();
    chk("R12 in-window feed", count, 16'h0020);
    chk("R12 no tof", mode[2], 1'b0);
    wr(AD_WIN, 16'hFFFF);

    // R4 sticky reset-arm
    wr(AD_MODE, 16'h0007);
    chk("R4 set", mode[1], 1'b1);
    wr(AD_MODE, 16'h0005);
    chk("R4 sticky", mode[1], 1'b1);

    // R9 sticky protect
    wr(AD_MODE, 16'h0015);
    chk("R9 set", mode[4], 1'b1);
    wr(AD_MODE, 16'h0005);
    chk("R9 sticky", mode[4], 1'b1);

    // R13 protect gating, R5 request
    wr(AD_RELOAD, 16'h0030);
    chk("R13 refused", reload, 16'h0020);
    chk("R13 violation tof", mode[2], 1'b1);
    chk("R5 req raised", rst_req, 1'b1);
    wr(AD_MODE, 16'h0001);
    chk("R5 req stays", rst_req, 1'b1);
    ticks(3);
    wr(AD_RELOAD, 16'h0030);
    chk("R13 accepted late", reload, 16'h0030);
    chk("R13 no violation", mode[2], 1'b0);
    feed();
    chk("R10 feed new constant", count, 16'h0030);

    // random phase: R2 R3 R5
    for (int it = 0; it < 20; it++) begin
      int r, steps;
      bit arm;
      do_reset();
      r = 1 + int'($urandom % 60);
      arm = 1'($urandom % 2);
      steps = 0;
      wr(AD_RELOAD, CW'(r));
      feed();
      wr(AD_MODE, arm ? 16'h0007 : 16'h0005);
      for (int c = 0; c < 100; c++) begin
        @(negedge clk);
        tick = 1'($urandom % 2);
        steps += int'(tick);
      end
      @(negedge clk); tick = 1'b0;
      chk("R2 random count", count, exp_count(r, steps));
      chk("R3 random tof", mode[2], (steps >= r));
      chk("R5 random req", rst_req, (steps >= r) && arm);
    end

    finish_up();
  end
endmodule